// File: doc/BRIEF.md
# Programmable UART Baud Rate Generator

This block derives every timing strobe a UART needs from a single reference clock. Nothing downstream runs on a derived clock. Each output is a one-cycle enable that the transmitter and receiver use as a qualifier on the reference clock.

A select input chooses the base rate: either every reference cycle, or one cycle in eight. A 16-bit sample divisor divides the base rate into an oversampling strobe. The divisor value 0 stops the strobe, and the value 1 passes the base rate straight through. An 8-bit bit divisor then divides the oversampling strobe by (divisor + 1) to form two bit-rate strobes, one for the transmitter and one for the receiver. The receiver strobe can be re-phased by a one-cycle resync request, which the receiver raises when it has confirmed a start bit.

The divisors are static inputs. They are meant to change only while both serial paths are idle. After a change, the block is reset before the paths are used again. The register that holds the bit divisor normally defaults to 15, which gives sixteen samples per bit.

Top module: `baud_gen`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, en_sample, en_tx and en_rx are all 0.
- R2: With base_div8 = 0 the base rate is every reference cycle. With base_div8 = 1 the base rate is one reference cycle in eight.
- R3: For sample_div >= 2, en_sample pulses once every sample_div base cycles. The spacing is sample_div × (1 or 8) reference cycles.
- R4: For sample_div = 1, en_sample follows the base rate one cycle later. It is high every cycle when base_div8 = 0 and every eighth cycle when base_div8 = 1.
- R5: For sample_div = 0, en_sample, en_tx and en_rx stay 0.
- R6: en_tx pulses once every bit_div + 1 en_sample pulses, one cycle after the en_sample pulse that completes the count. bit_div = 0 gives one en_tx per en_sample.
- R7: After reset, and until the first rx_resync, en_rx is identical to en_tx in every cycle.
- R8: A cycle with rx_resync = 1 restarts the receive count. en_rx is 0 in the following cycle. The next en_rx comes one cycle after the (bit_div + 1)-th en_sample pulse seen after the resync cycle. An en_sample in the resync cycle itself is not counted.
- R9: Whenever its spacing is more than one cycle, each enable is high for exactly one reference cycle per pulse.
- R10: With base_div8 = 0, sample_div = 85 and bit_div = 15, en_tx pulses every 1360 reference cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_div8 | input | 1 | 0: base rate every cycle; 1: base rate every eighth cycle |
| sample_div | input | 16 | Oversampling divisor (0 stops, 1 bypasses) |
| bit_div | input | 8 | Samples per bit minus one |
| rx_resync | input | 1 | One-cycle request to re-phase the receive strobe |
| en_sample | output | 1 | Oversampling enable |
| en_tx | output | 1 | Transmit bit-rate enable |
| en_rx | output | 1 | Receive bit-rate enable |

## Verification
A corrupted prescaler or sample counter shows up as a wrong spacing between en_sample pulses. This is visible within one sample period, at most 8 × sample_div cycles. The fault then carries into en_tx and en_rx, scaled by bit_div + 1.

A wrong bit counter, or a resync that is lost or mishandled, is seen at the next receive pulse. That pulse is either early, late, or out of step with en_tx. The bench therefore measures pulse spacings, counts sample strobes after a resync, and compares the two bit strobes cycle by cycle. These checks are run for random divisor settings as well as for the 0, 1 and largest-period corner cases.

// File: rtl/baud_pkg.sv
package baud_pkg;

    typedef enum logic {
        BASE_FULL = 1'b0,
        BASE_DIV8 = 1'b1
    } base_sel_e;

    localparam int unsigned PRESCALE_RATIO = 8;
    localparam int unsigned LANE_TX        = 0;
    localparam int unsigned LANE_RX        = 1;
    localparam int unsigned LANE_COUNT     = 2;

endpackage

// File: rtl/baud_prescale.sv
module baud_prescale #(
    parameter int unsigned RATIO = baud_pkg::PRESCALE_RATIO
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_div,
    output logic base_en
);
    localparam int unsigned PW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) st_d.cnt = '0;
        else                  st_d.cnt = st_q.cnt + PW'(1);
        base_en = (sel_div == baud_pkg::BASE_DIV8) ? (st_q.cnt == LAST) : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/baud_cd_div.sv
module baud_cd_div #(
    parameter int unsigned CD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            base_en,
    input  logic [CD_W-1:0] cd,
    output logic            samp_en
);
    typedef struct packed {
        logic [CD_W-1:0] cnt;
        logic            pulse;
    } cd_state_t;

    cd_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (cd == '0) begin
            st_d.cnt = '0;
        end else if (cd == CD_W'(1)) begin
            st_d.cnt   = '0;
            st_d.pulse = base_en;
        end else if (base_en) begin
            if (st_q.cnt >= cd - CD_W'(1)) begin
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CD_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign samp_en = st_q.pulse;
endmodule

// File: rtl/baud_bit_div.sv
module baud_bit_div #(
    parameter int unsigned BD_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [BD_W-1:0] bdiv,
    input  logic            realign,
    output logic            bit_en
);
    typedef struct packed {
        logic [BD_W-1:0] cnt;
        logic            pulse;
    } bit_state_t;

    bit_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (realign) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt >= bdiv) begin
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + BD_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_en = st_q.pulse;
endmodule

// File: rtl/baud_gen.sv
module baud_gen #(
    parameter int unsigned CD_W = 16,
    parameter int unsigned BD_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            base_div8,
    input  logic [CD_W-1:0] sample_div,
    input  logic [BD_W-1:0] bit_div,
    input  logic            rx_resync,
    output logic            en_sample,
    output logic            en_tx,
    output logic            en_rx
);
    import baud_pkg::*;

    logic                  base_en;
    logic                  samp_en;
    logic [LANE_COUNT-1:0] lane_en;

    baud_prescale #(.RATIO(PRESCALE_RATIO)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_div (base_div8),
        .base_en (base_en)
    );

    baud_cd_div #(.CD_W(CD_W)) u_cd (
        .clk     (clk),
        .rst_n   (rst_n),
        .base_en (base_en),
        .cd      (sample_div),
        .samp_en (samp_en)
    );

    for (genvar gi = 0; gi < LANE_COUNT; gi++) begin : g_lane
        logic lane_realign;
        if (gi == LANE_RX) begin : g_rx
            assign lane_realign = rx_resync;
        end else begin : g_tx
            assign lane_realign = 1'b0;
        end

        baud_bit_div #(.BD_W(BD_W)) u_bit (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (samp_en),
            .bdiv    (bit_div),
            .realign (lane_realign),
            .bit_en  (lane_en[gi])
        );
    end

    assign en_sample = samp_en;
    assign en_tx     = lane_en[LANE_TX];
    assign en_rx     = lane_en[LANE_RX];
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
    parameter int unsigned CD_W = 16,
    parameter int unsigned BD_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            base_div8,
    input logic [CD_W-1:0] sample_div,
    input logic [BD_W-1:0] bit_div,
    input logic            rx_resync,
    input logic            en_sample,
    input logic            en_tx,
    input logic            en_rx
);
    a_r5_cd_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_div == '0) |=> !en_sample)
        else $error("R5 en_sample with zero divisor");

    a_r4_cd_one_full: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_div == CD_W'(1) && !base_div8) |=> en_sample)
        else $error("R4 bypass strobe missing");

    a_r2_div8_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (en_sample && base_div8 && $past(base_div8)) |-> !$past(en_sample))
        else $error("R2 divide-by-8 base too fast");

    a_r6_tx_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        en_tx |-> $past(en_sample))
        else $error("R6 en_tx without preceding sample");

    a_r8_rx_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        en_rx |-> $past(en_sample))
        else $error("R8 en_rx without preceding sample");

    a_r8_resync_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rx_resync |=> !en_rx)
        else $error("R8 en_rx right after resync");
endmodule

bind baud_gen baud_gen_chk #(.CD_W(CD_W), .BD_W(BD_W)) i_baud_gen_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_div8  (base_div8),
    .sample_div (sample_div),
    .bit_div    (bit_div),
    .rx_resync  (rx_resync),
    .en_sample  (en_sample),
    .en_tx      (en_tx),
    .en_rx      (en_rx)
);

// File: tb/test_baud_gen.sv
module test_baud_gen;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_div8 = 1'b0;
    logic [15:0] sample_div = 16'd4;
    logic [7:0]  bit_div = 8'd15;
    logic        rx_resync = 1'b0;
    logic        en_sample, en_tx, en_rx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_gen i_baud_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_div8  (base_div8),
        .sample_div (sample_div),
        .bit_div    (bit_div),
        .rx_resync  (rx_resync),
        .en_sample  (en_sample),
        .en_tx      (en_tx),
        .en_rx      (en_rx)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sample_gap(input bit d8, input int cd);
        return cd * (d8 ? 8 : 1);
    endfunction

    function automatic bit sig_of(input int which);
        case (which)
            0:       return en_sample;
            1:       return en_tx;
            default: return en_rx;
        endcase
    endfunction

    task automatic apply_cfg(input bit d8, input int cd, input int bd);
        @(negedge clk);
        rst_n      = 1'b0;
        base_div8  = d8;
        sample_div = 16'(cd);
        bit_div    = 8'(bd);
        rx_resync  = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // cycles between two consecutive pulses, after skipping the first gap
    task automatic measure(input int which, input int limit, output int gap);
        int n;
        gap = -1;
        for (int rep = 0; rep < 2; rep++) begin
            n = 0;
            while (!sig_of(which) && n < limit) begin @(negedge clk); n++; end
            if (n >= limit) return;
            n = 0;
            do begin @(negedge clk); n++; end while (!sig_of(which) && n < limit);
            if (n >= limit) return;
            gap = n;
        end
    endtask

    task automatic resync_trial(input int bd, input string tag);
        int cnt;
        int cyc;
        @(negedge clk);
        rx_resync = 1'b1;
        @(negedge clk);
        rx_resync = 1'b0;
        check(en_rx == 1'b0, {tag, " quiet after resync"}, en_rx, 0);
        cnt = 0;
        cyc = 0;
        while (!en_rx && cyc < 20000) begin
            if (en_sample) cnt++;
            @(negedge clk);
            cyc++;
        end
        check(cnt == bd + 1, tag, cnt, bd + 1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int gap;
        int seed;
        int cd, bd;
        bit d8;
        int hits, twice, mism;

        seed = $urandom(32'd4242);

        // R1 reset state
        @(negedge clk);
        check({en_sample, en_tx, en_rx} == 3'b000, "R1 in reset", {en_sample, en_tx, en_rx}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        check({en_sample, en_tx, en_rx} == 3'b000, "R1 first cycle", {en_sample, en_tx, en_rx}, 0);

        // R10 reference example
        apply_cfg(1'b0, 85, 15);
        measure(1, 5000, gap);
        check(gap == 1360, "R10 tx period", gap, 1360);
        measure(0, 500, gap);
        check(gap == 85, "R3 sample period cd=85", gap, 85);

        // R4 bypass with both bases
        apply_cfg(1'b0, 1, 0);
        measure(0, 50, gap);
        check(gap == 1, "R4 cd=1 full base", gap, 1);
        measure(1, 50, gap);
        check(gap == 1, "R6 bdiv=0 every sample", gap, 1);
        apply_cfg(1'b1, 1, 3);
        measure(0, 100, gap);
        check(gap == 8, "R4 cd=1 div8 base", gap, 8);
        measure(1, 200, gap);
        check(gap == 32, "R2 R6 div8 tx period", gap, 32);

        // R5 zero divisor
        apply_cfg(1'b0, 0, 2);
        hits = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (en_sample || en_tx || en_rx) hits++;
        end
        check(hits == 0, "R5 cd=0 quiet", hits, 0);

        // R9 pulse width and R7 tx/rx alignment
        apply_cfg(1'b0, 3, 2);
        twice = 0;
        mism = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (en_tx && en_rx !== en_tx) mism++;
            if (!en_tx && en_rx) mism++;
            if (en_tx) begin
                @(negedge clk);
                if (en_tx) twice++;
                if (en_rx !== en_tx) mism++;
            end
        end
        check(twice == 0, "R9 single-cycle tx pulse", twice, 0);
        check(mism == 0, "R7 rx tracks tx", mism, 0);

        // R8 directed resync
        apply_cfg(1'b0, 2, 5);
        repeat (7) @(negedge clk);
        resync_trial(5, "R8 resync bdiv=5");
        apply_cfg(1'b1, 2, 0);
        repeat (11) @(negedge clk);
        resync_trial(0, "R8 resync bdiv=0");

        // random sweep: R3, R6, R8
        for (int t = 0; t < 8; t++) begin
            d8 = 1'($urandom_range(0, 1));
            cd = int'($urandom_range(2, 16));
            bd = int'($urandom_range(0, 12));
            apply_cfg(d8, cd, bd);
            measure(0, 400, gap);
            check(gap == sample_gap(d8, cd), "R3 random sample period", gap, sample_gap(d8, cd));
            measure(1, 5000, gap);
            check(gap == sample_gap(d8, cd) * (bd + 1), "R6 random tx period", gap,
                  sample_gap(d8, cd) * (bd + 1));
            repeat (int'($urandom_range(1, 40))) @(negedge clk);
            resync_trial(bd, "R8 random resync");
            measure(2, 5000, gap);
            check(gap == sample_gap(d8, cd) * (bd + 1), "R8 rx period after resync", gap,
                  sample_gap(d8, cd) * (bd + 1));
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule